// File: doc/BRIEF.md
# Wrapping Index Address Generator

This block forms data addresses for a small signal-processing core. It keeps one 14-bit pointer into read-only constant storage and three 10-bit RAM pointers. Each RAM pointer has its own base and limit register. A 12-bit bias register can offset any RAM address. A step register supplies a signed stride for the third RAM pointer.

Each cycle, an access request selects a space and pointer, a post-update mode and an optional bias, or it gives a direct offset instead of a pointer. The block returns the effective address in the same cycle. At the next clock edge it updates the selected pointer. A RAM pointer that sits exactly on its limit reloads its base instead of stepping. A separate write port loads pointers, bases, limits, the bias register and the step register. A loaded pointer serves as an address from the next cycle on.

Top module: `wrap_index_agu`

## Requirements
- R1: After reset, every pointer, base, limit, the bias register and the step value are zero, so an undecorated pointer access returns address 0.
- R2: The address is combinational in the request cycle. `ea_ram` is 1 exactly when `acc_sel` is 1, 2 or 3 (RAM). For an unbiased indexed access, `ea` is the selected pointer, zero-extended. Select 0 means constant space and uses the 14-bit pointer.
- R3: Mode codes are 0 = none, 1 = +1, 2 = −1, 3 = variable step. The constant pointer (select 0) moves only in mode 1. It wraps naturally from 16383 to 0 and has no limit check. Modes 0, 2 and 3 leave it unchanged.
- R4: RAM pointers 1 and 2 move in modes 1 and 2. After the access, a pointer equal to its limit reloads its base. Otherwise it adds +1 or −1, modulo 1024. Modes 0 and 3 leave them unchanged.
- R5: RAM pointer 3 moves only in mode 3, by the step value taken as a signed 10-bit number. It uses the same equality wrap rule. A pointer that jumps over its limit without landing on it keeps stepping and does not wrap.
- R6: A step value written at clock edge E is used by mode-3 accesses that complete at edge E+2 and later. An access that completes at edge E+1 still uses the previous step value.
- R7: When `acc_bias` is 1 on a RAM access, the address is (bias + signed 10-bit pointer or offset) mod 4096. `acc_bias` has no effect in constant space.
- R8: For a direct access (`acc_direct` = 1), constant space gives `acc_offset[13:0]`. RAM gives `acc_offset[9:0]`, which is zero-extended when unbiased and added as a signed value when biased.
- R9: Write codes on `wr_code` are: 0 to 3 pointer 0 to 3; 5 to 7 base of RAM pointer 1 to 3; 9 to 11 limit of RAM pointer 1 to 3; 12 load bias; 13 add the signed `wr_data[11:0]` to bias, mod 4096; 14 load step from `wr_data[9:0]`. Codes 4, 8 and 15 change nothing.
- R10: A pointer write wins over a post-update of the same pointer in the same cycle. The written value is the address for the next access.
- R11: A direct access, or a cycle with `acc_valid` = 0, changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request present |
| acc_sel | input | 2 | 0 constant pointer, 1..3 RAM pointer |
| acc_mode | input | 2 | Post-update mode |
| acc_bias | input | 1 | Add bias register (RAM only) |
| acc_direct | input | 1 | Use offset instead of pointer |
| acc_offset | input | 14 | Direct offset |
| wr_en | input | 1 | Register write strobe |
| wr_code | input | 4 | Write target code |
| wr_data | input | 14 | Write value |
| ea | output | 14 | Effective address |
| ea_ram | output | 1 | Address is in RAM space |

## Verification
The checker assumes that reset is asserted before the first clock edge and that the inputs are stable around each rising edge. The wrap and step properties also assume that no write to the same pointer or base lands in the checked cycle. These properties are therefore guarded on the write-port state and on the same-cycle write. The bench changes inputs only on the falling edge and holds them stable until the rising edge. It mixes random requests and writes, including the unused write codes, with directed sequences. The directed sequences cover the exact-limit wrap, the stride that overshoots its limit, the first cycle after a step write, and the colliding write.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int ROM_AW  = 14;
  localparam int RAM_PW  = 10;
  localparam int BIAS_W  = 12;
  localparam int EA_W    = ROM_AW;
  localparam int NSLOT   = 3;
  localparam int CODE_W  = 4;

  typedef enum logic [1:0] {
    MODE_NONE = 2'd0,
    MODE_INC  = 2'd1,
    MODE_DEC  = 2'd2,
    MODE_STEP = 2'd3
  } mode_e;

  typedef enum logic [CODE_W-1:0] {
    WC_PTR0     = 4'd0,
    WC_BIAS_LD  = 4'd12,
    WC_BIAS_ADD = 4'd13,
    WC_STEP     = 4'd14
  } wr_code_e;

  localparam logic [CODE_W-1:0] WC_BASE0 = 4'd4;
  localparam logic [CODE_W-1:0] WC_LIM0  = 4'd8;

  function automatic logic [RAM_PW-1:0] wrap_next(
    input logic [RAM_PW-1:0] ptr,
    input logic [RAM_PW-1:0] base,
    input logic [RAM_PW-1:0] limit,
    input logic [RAM_PW-1:0] delta);
    return (ptr == limit) ? base : ptr + delta;
  endfunction

  function automatic logic [BIAS_W-1:0] bias_sum(
    input logic [BIAS_W-1:0] bias,
    input logic [RAM_PW-1:0] val);
    return bias + {{(BIAS_W-RAM_PW){val[RAM_PW-1]}}, val};
  endfunction
endpackage

// File: rtl/agu_rom_ptr.sv
module agu_rom_ptr
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ROM_AW-1:0] ld_val,
  input  logic              adv,
  output logic [ROM_AW-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (ld)  ptr_q <= ld_val;
    else if (adv) ptr_q <= ptr_q + 1'b1;
  end
endmodule

// File: rtl/agu_ram_slot.sv
module agu_ram_slot
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_ptr,
  input  logic              ld_base,
  input  logic              ld_lim,
  input  logic [RAM_PW-1:0] wr_val,
  input  logic              adv,
  input  logic [RAM_PW-1:0] delta,
  output logic [RAM_PW-1:0] ptr_q,
  output logic [RAM_PW-1:0] base_q,
  output logic [RAM_PW-1:0] lim_q,
  output logic              wrap_hit
);
  assign wrap_hit = adv && !ld_ptr && (ptr_q == lim_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      base_q <= '0;
      lim_q  <= '0;
    end else begin
      if (ld_ptr)   ptr_q <= wr_val;
      else if (adv) ptr_q <= wrap_next(ptr_q, base_q, lim_q, delta);
      if (ld_base)  base_q <= wr_val;
      if (ld_lim)   lim_q  <= wr_val;
    end
  end
endmodule

// File: rtl/agu_bias_step.sv
module agu_bias_step
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_bias,
  input  logic              add_bias,
  input  logic              ld_step,
  input  logic [EA_W-1:0]   wr_data,
  output logic [BIAS_W-1:0] bias_q,
  output logic [RAM_PW-1:0] step_raw,
  output logic [RAM_PW-1:0] step_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bias_q   <= '0;
      step_raw <= '0;
      step_q   <= '0;
    end else begin
      if (ld_bias)       bias_q <= wr_data[BIAS_W-1:0];
      else if (add_bias) bias_q <= bias_q + wr_data[BIAS_W-1:0];
      if (ld_step)       step_raw <= wr_data[RAM_PW-1:0];
      step_q <= step_raw;
    end
  end
endmodule

// File: rtl/agu_ea_form.sv
module agu_ea_form
  import agu_pkg::*;
(
  input  logic                         acc_sel_rom,
  input  logic [1:0]                   acc_sel,
  input  logic                         acc_bias,
  input  logic                         acc_direct,
  input  logic [EA_W-1:0]              acc_offset,
  input  logic [ROM_AW-1:0]            rom_ptr,
  input  logic [NSLOT:1][RAM_PW-1:0]   ram_ptr,
  input  logic [BIAS_W-1:0]            bias,
  output logic [EA_W-1:0]              ea,
  output logic                         ea_ram
);
  logic [RAM_PW-1:0] ram_val;
  logic [RAM_PW-1:0] ptr_pick;

  always_comb begin
    case (acc_sel)
      2'd1:    ptr_pick = ram_ptr[1];
      2'd2:    ptr_pick = ram_ptr[2];
      default: ptr_pick = ram_ptr[3];
    endcase
  end

  assign ram_val = acc_direct ? acc_offset[RAM_PW-1:0] : ptr_pick;

  always_comb begin
    if (acc_sel_rom) begin
      ea_ram = 1'b0;
      ea     = acc_direct ? acc_offset : rom_ptr;
    end else begin
      ea_ram = 1'b1;
      if (acc_bias) ea = {{(EA_W-BIAS_W){1'b0}}, bias_sum(bias, ram_val)};
      else          ea = {{(EA_W-RAM_PW){1'b0}}, ram_val};
    end
  end
endmodule

// File: rtl/wrap_index_agu.sv
module wrap_index_agu
  import agu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [1:0]        acc_sel,
  input  logic [1:0]        acc_mode,
  input  logic              acc_bias,
  input  logic              acc_direct,
  input  logic [EA_W-1:0]   acc_offset,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic [EA_W-1:0]   wr_data,
  output logic [EA_W-1:0]   ea,
  output logic              ea_ram
);
  logic                        idx_req;
  logic                        sel_rom;
  logic [ROM_AW-1:0]           rom_ptr;
  logic                        rom_adv;
  logic [NSLOT:1][RAM_PW-1:0]  ram_ptr;
  logic [NSLOT:1][RAM_PW-1:0]  ram_base;
  logic [NSLOT:1][RAM_PW-1:0]  ram_lim;
  logic [NSLOT:1]              slot_adv;
  logic [NSLOT:1]              wrap_hit;
  logic [BIAS_W-1:0]           bias_q;
  logic [RAM_PW-1:0]           step_raw;
  logic [RAM_PW-1:0]           step_q;

  // indexed (pointer-based) access event
  assign idx_req = acc_valid && !acc_direct;
  assign sel_rom = (acc_sel == 2'd0);
  assign rom_adv = idx_req && sel_rom && (acc_mode == MODE_INC);

  agu_rom_ptr u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (wr_en && (wr_code == WC_PTR0)),
    .ld_val (wr_data[ROM_AW-1:0]),
    .adv    (rom_adv),
    .ptr_q  (rom_ptr)
  );

  for (genvar gi = 1; gi <= NSLOT; gi++) begin : g_slot
    logic [RAM_PW-1:0] delta;
    logic              mode_ok;
    if (gi == NSLOT) begin : g_stride
      assign mode_ok = (acc_mode == MODE_STEP);
      assign delta   = step_q;
    end else begin : g_unit
      assign mode_ok = (acc_mode == MODE_INC) || (acc_mode == MODE_DEC);
      assign delta   = (acc_mode == MODE_DEC) ? '1 : RAM_PW'(1);
    end
    assign slot_adv[gi] = idx_req && (acc_sel == 2'(gi)) && mode_ok;

    agu_ram_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_ptr   (wr_en && (wr_code == CODE_W'(gi))),
      .ld_base  (wr_en && (wr_code == WC_BASE0 + CODE_W'(gi))),
      .ld_lim   (wr_en && (wr_code == WC_LIM0 + CODE_W'(gi))),
      .wr_val   (wr_data[RAM_PW-1:0]),
      .adv      (slot_adv[gi]),
      .delta    (delta),
      .ptr_q    (ram_ptr[gi]),
      .base_q   (ram_base[gi]),
      .lim_q    (ram_lim[gi]),
      .wrap_hit (wrap_hit[gi])
    );
  end

  agu_bias_step u_bias (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_bias  (wr_en && (wr_code == WC_BIAS_LD)),
    .add_bias (wr_en && (wr_code == WC_BIAS_ADD)),
    .ld_step  (wr_en && (wr_code == WC_STEP)),
    .wr_data  (wr_data),
    .bias_q   (bias_q),
    .step_raw (step_raw),
    .step_q   (step_q)
  );

  agu_ea_form u_ea (
    .acc_sel_rom (sel_rom),
    .acc_sel     (acc_sel),
    .acc_bias    (acc_bias),
    .acc_direct  (acc_direct),
    .acc_offset  (acc_offset),
    .rom_ptr     (rom_ptr),
    .ram_ptr     (ram_ptr),
    .bias        (bias_q),
    .ea          (ea),
    .ea_ram      (ea_ram)
  );
endmodule

// File: rtl/agu_checker.sv
module agu_checker
  import agu_pkg::*;
(
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_valid,
  input logic [1:0]                  acc_sel,
  input logic [1:0]                  acc_mode,
  input logic                        acc_direct,
  input logic                        wr_en,
  input logic [CODE_W-1:0]           wr_code,
  input logic [EA_W-1:0]             wr_data,
  input logic                        ea_ram,
  input logic [ROM_AW-1:0]           rom_ptr,
  input logic [NSLOT:1][RAM_PW-1:0]  ram_ptr,
  input logic [NSLOT:1][RAM_PW-1:0]  ram_base,
  input logic [NSLOT:1][RAM_PW-1:0]  ram_lim,
  input logic [NSLOT:1]              wrap_hit,
  input logic [RAM_PW-1:0]           step_raw,
  input logic [RAM_PW-1:0]           step_q
);
  a_r2_space_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (ea_ram == (acc_sel != 2'd0)));

  a_r3_rom_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_direct && acc_sel == 2'd0 && acc_mode == 2'd1
     && !(wr_en && wr_code == 4'd0))
    |=> rom_ptr == $past(rom_ptr) + 1'b1);

  a_r4_x1_limit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_direct && acc_sel == 2'd1 && acc_mode == 2'd1
     && ram_ptr[1] == ram_lim[1] && !(wr_en && (wr_code == 4'd1 || wr_code == 4'd5)))
    |=> ram_ptr[1] == $past(ram_base[1]));

  a_r5_x3_wrap_event: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_hit[3] && !(wr_en && wr_code == 4'd7)) |=> ram_ptr[3] == $past(ram_base[3]));

  a_r6_step_delay: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> step_q == $past(step_raw));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_code == 4'd3) |=> ram_ptr[3] == $past(wr_data[RAM_PW-1:0]));

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_valid && !wr_en) |=> ($stable(rom_ptr) && $stable(ram_ptr)));
endmodule

bind wrap_index_agu agu_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_valid  (acc_valid),
  .acc_sel    (acc_sel),
  .acc_mode   (acc_mode),
  .acc_direct (acc_direct),
  .wr_en      (wr_en),
  .wr_code    (wr_code),
  .wr_data    (wr_data),
  .ea_ram     (ea_ram),
  .rom_ptr    (rom_ptr),
  .ram_ptr    (ram_ptr),
  .ram_base   (ram_base),
  .ram_lim    (ram_lim),
  .wrap_hit   (wrap_hit),
  .step_raw   (step_raw),
  .step_q     (step_q)
);

// File: tb/wrap_index_agu_test.sv
`timescale 1ns/1ps
module wrap_index_agu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_sel = '0;
  logic [1:0]  acc_mode = '0;
  logic        acc_bias = 1'b0;
  logic        acc_direct = 1'b0;
  logic [13:0] acc_offset = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_code = '0;
  logic [13:0] wr_data = '0;
  logic [13:0] ea;
  logic        ea_ram;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wrap_index_agu uut (.*);

  // bench-side model
  logic [13:0] m_x0;
  logic [9:0]  m_p [1:3];
  logic [9:0]  m_b [1:3];
  logic [9:0]  m_l [1:3];
  logic [11:0] m_bias;
  logic [9:0]  m_r3, m_sh;

  function automatic int signed10(input logic [9:0] v);
    int x = int'(v);
    if (x >= 512) x -= 1024;
    return x;
  endfunction

  function automatic logic [14:0] model_ea(input logic [1:0] s, input bit be, dr,
                                           input logic [13:0] off);
    logic [9:0] v;
    int sum;
    if (s == 2'd0) return {1'b0, dr ? off : m_x0};
    v = dr ? off[9:0] : m_p[s];
    if (!be) return {1'b1, 4'b0, v};
    sum = (int'(m_bias) + signed10(v)) & 4095;
    return {1'b1, 14'(sum)};
  endfunction

  task automatic model_tick(input bit v, input logic [1:0] s, m, input bit dr,
                            input bit we, input logic [3:0] wc, input logic [13:0] wd);
    if (v && !dr) begin
      if (s == 2'd0) begin
        if (m == 2'd1) m_x0 = m_x0 + 14'd1;
      end else if ((s != 2'd3 && (m == 2'd1 || m == 2'd2)) || (s == 2'd3 && m == 2'd3)) begin
        if (m_p[s] == m_l[s]) m_p[s] = m_b[s];
        else if (s == 2'd3)   m_p[s] = 10'(signed10(m_p[s]) + signed10(m_sh));
        else if (m == 2'd1)   m_p[s] = m_p[s] + 10'd1;
        else                  m_p[s] = m_p[s] - 10'd1;
      end
    end
    m_sh = m_r3;
    if (we) begin
      case (wc)
        4'd0: m_x0 = wd;
        4'd1, 4'd2, 4'd3: m_p[wc[1:0]] = wd[9:0];
        4'd5, 4'd6, 4'd7: m_b[wc[1:0]] = wd[9:0];
        4'd9, 4'd10, 4'd11: m_l[wc[1:0] - 2'd0] = wd[9:0];
        4'd12: m_bias = wd[11:0];
        4'd13: m_bias = m_bias + wd[11:0];
        4'd14: m_r3 = wd[9:0];
        default: ;
      endcase
    end
  endtask

  task automatic cyc(input bit v, input logic [1:0] s, m, input bit be, dr,
                     input logic [13:0] off, input bit we, input logic [3:0] wc,
                     input logic [13:0] wd, input string tag);
    logic [14:0] exp;
    @(negedge clk);
    acc_valid = v; acc_sel = s; acc_mode = m; acc_bias = be; acc_direct = dr;
    acc_offset = off; wr_en = we; wr_code = wc; wr_data = wd;
    #1;
    if (v) begin
      exp = model_ea(s, be, dr, off);
      n_run++;
      if ({ea_ram, ea} !== exp) begin
        n_fail++;
        $display("FAIL %s: ea_ram/ea got %b/%0d expected %b/%0d", tag, ea_ram, ea, exp[14], exp[13:0]);
      end
    end
    model_tick(v, s, m, dr, we, wc, wd);
  endtask

  task automatic wr(input logic [3:0] wc, input logic [13:0] wd);
    cyc(0, 0, 0, 0, 0, 0, 1, wc, wd, "R9");
  endtask

  task automatic peek(input logic [1:0] s, input string tag);
    cyc(1, s, 2'd0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_x0 = '0; m_bias = '0; m_r3 = '0; m_sh = '0;
    for (int i = 1; i <= 3; i++) begin m_p[i] = '0; m_b[i] = '0; m_l[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) peek(2'(s), "R1");
    cyc(1, 2'd1, 0, 1, 1, 14'd0, 0, 0, 0, "R1 bias");

    // R10 load then use next cycle; R2 pointer readback
    wr(4'd1, 14'd100);
    peek(2'd1, "R10");
    wr(4'd0, 14'd9000);
    peek(2'd0, "R2");

    // R4 increment wrap 5..8
    wr(4'd5, 14'd5); wr(4'd9, 14'd8); wr(4'd1, 14'd5);
    for (int k = 0; k < 6; k++) cyc(1, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0, "R4 inc");
    // R4 decrement wrap 20..17
    wr(4'd6, 14'd20); wr(4'd10, 14'd17); wr(4'd2, 14'd20);
    for (int k = 0; k < 6; k++) cyc(1, 2'd2, 2'd2, 0, 0, 0, 0, 0, 0, "R4 dec");
    cyc(1, 2'd2, 2'd3, 0, 0, 0, 0, 0, 0, "R4 mode3 ignored");
    peek(2'd2, "R4");

    // R5 stride 3, base 10, limit 22
    wr(4'd14, 14'd3); wr(4'd7, 14'd10); wr(4'd11, 14'd22); wr(4'd3, 14'd10);
    for (int k = 0; k < 7; k++) cyc(1, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, "R5 wrap");
    // R5 overshoot: limit 21 never hit
    wr(4'd11, 14'd21); wr(4'd3, 14'd10);
    for (int k = 0; k < 7; k++) cyc(1, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, "R5 pass");

    // R6 step delay: first access after write uses old step 3
    wr(4'd11, 14'd500); wr(4'd3, 14'd40);
    wr(4'd14, 14'h3FB);
    cyc(1, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, "R6 old step");
    cyc(1, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, "R6 old step applied");
    cyc(1, 2'd3, 2'd3, 0, 0, 0, 0, 0, 0, "R6 new step applied");
    peek(2'd3, "R6");

    // R3 constant pointer wraps with no limit
    wr(4'd0, 14'd16383);
    cyc(1, 2'd0, 2'd1, 0, 0, 0, 0, 0, 0, "R3");
    peek(2'd0, "R3 wrapped");
    cyc(1, 2'd0, 2'd2, 0, 0, 0, 0, 0, 0, "R3 dec");
    peek(2'd0, "R3 dec ignored");

    // R7 bias
    wr(4'd12, 14'd4090); wr(4'd1, 14'd10);
    cyc(1, 2'd1, 2'd0, 1, 0, 0, 0, 0, 0, "R7 wrap");
    wr(4'd1, 14'd1023);
    cyc(1, 2'd1, 2'd0, 1, 0, 0, 0, 0, 0, "R7 negative");
    cyc(1, 2'd0, 2'd0, 1, 0, 0, 0, 0, 0, "R7 rom ignores bias");
    // R8 direct
    cyc(1, 2'd0, 2'd0, 1, 1, 14'd12345, 0, 0, 0, "R8 rom");
    cyc(1, 2'd2, 2'd0, 0, 1, 14'h3F00, 0, 0, 0, "R8 ram");
    cyc(1, 2'd2, 2'd0, 1, 1, 14'h0200, 0, 0, 0, "R8 biased");
    // R9 bias add negative and unused codes
    wr(4'd13, 14'h0FFB);
    cyc(1, 2'd1, 2'd0, 1, 1, 14'd0, 0, 0, 0, "R9 add");
    wr(4'd4, 14'd77); wr(4'd8, 14'd77); wr(4'd15, 14'd77);
    for (int s = 0; s < 4; s++) peek(2'(s), "R9 unused");

    // R10 collision; R11 direct does not move
    cyc(1, 2'd1, 2'd1, 0, 0, 0, 1, 4'd1, 14'd300, "R10 collide");
    peek(2'd1, "R10");
    cyc(1, 2'd1, 2'd1, 0, 1, 14'd7, 0, 0, 0, "R11 direct");
    peek(2'd1, "R11");
    cyc(0, 2'd1, 2'd1, 0, 0, 0, 0, 0, 0, "R11 idle");
    peek(2'd1, "R11");

    // random mix
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r = $urandom;
      cyc(r[0] | r[1], r[3:2], r[5:4], r[6], r[9:8] == 2'b11, 14'($urandom),
          r[12:10] < 3'd2, r[16:13], 14'($urandom), "R2 random");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule